// File: doc/BRIEF.md
# Floppy Interface Control Switch Latch

This block sits between the host I/O bus and the rest of a floppy disk interface card. Any access to the card's sixteen-address I/O window, read or write, updates one of eight single-bit control switches. Offset bits [3:1] pick the switch and offset bit 0 is the value stored. The same access also decides whether the card drives the bus. When offset bit 0 is low, the current data-register value goes out on the bus. When it is high, the card leaves the bus floating.

The switches feed the rest of the card. Switches 0 to 3 are the stepper phase lines to both drives. Switch 4 is the motor request and switch 5 picks the drive. Switches 6 and 7 are mode inputs to the separate read/write data sequencer.

A motor timer with three states turns the motor request into a motor-on signal that stays active for a long retriggerable delay after the request clears. The states are `M_OFF`, `M_HELD` and `M_COAST`:
- `M_OFF` goes to `M_HELD` when the request rises.
- `M_HELD` goes to `M_COAST` when the request falls.
- `M_COAST` goes back to `M_HELD` when the request returns.
- `M_COAST` goes to `M_OFF` when the last tick of the delay expires.

Motor-on, combined with the select switch, produces one enable line per drive.

Top module: `floppy_ctl_latch`

## Requirements
- R1: On a clock edge with `acc_stb` high, switch number `acc_ofs[3:1]` takes the value `acc_ofs[0]`. The new value is visible from the following cycle. Every access updates a switch, whatever the bus direction.
- R2: Switches not addressed by an access keep their value. With `acc_stb` low, no switch changes.
- R3: In a cycle with `acc_stb` high and `acc_ofs[0]` low, `bus_oe` is 1 and `bus_dout` equals `dreg_in` in that same cycle. In every other cycle `bus_oe` is 0 and `bus_dout` is 0.
- R4: While `rst_n` is low, all eight switches are cleared, `motor_on` is 0 and `drv_en` is 0.
- R5: While switch 4 (motor request) is set, the delay counter is reloaded to `DELAY_TICKS` every cycle and `motor_on` is 1.
- R6: After switch 4 clears, `motor_on` stays 1 for exactly `DELAY_TICKS` more cycles, counted from the first cycle in which the cleared switch is visible, and then drops to 0.
- R7: If switch 4 is set again while the delay runs, the counter reloads at once and `motor_on` does not drop for any cycle. The full delay is then measured from the next clearing.
- R8: `drv_en[0]` is `motor_on` AND NOT switch 5, and `drv_en[1]` is `motor_on` AND switch 5. At most one is high.
- R9: `phase[i]` equals switch i for i = 0 to 3. `mode[0]` equals switch 6 and `mode[1]` equals switch 7.
- R10: Changing switch 5 during the off-delay moves the enable to the other drive on the next cycle without shortening or extending the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz card clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Single-cycle strobe for an access to the card I/O window |
| acc_ofs | input | 4 | Offset of the access within the window |
| dreg_in | input | 8 | Current value of the sequencer's data register |
| bus_oe | output | 1 | Card drives the host data bus this cycle |
| bus_dout | output | 8 | Value driven onto the bus (0 when not driving) |
| phase | output | 4 | Stepper phase lines to both drives |
| mode | output | 2 | Mode inputs to the data sequencer |
| motor_on | output | 1 | Delayed motor-on |
| drv_en | output | 2 | Per-drive enable lines |

## Verification
The bench measures the off-delay to the exact cycle. A timer that counts one tick too many or too few fails the on/off pair of checks at the boundary.

It re-requests the motor halfway through the delay and watches `motor_on` on every cycle. A timer that lets the state fall to `M_OFF` before reloading shows up as a one-cycle low, and a timer that fails to reload drops early.

It flips the drive select during the delay. This catches enables that ignore the select, and a timer that restarts on any access.

Walking patterns over all eight switch addresses catch swapped select bits and bleed into neighbouring switches. Even and odd offsets are compared for bus drive, which catches an inverted output-enable.

// File: rtl/disk_latch_pkg.sv
package disk_latch_pkg;
    typedef enum logic [1:0] {
        M_OFF   = 2'd0,
        M_HELD  = 2'd1,
        M_COAST = 2'd2
    } motor_state_t;

    localparam int SW_PHASE0 = 0;
    localparam int N_PHASE   = 4;
    localparam int SW_MOTOR  = 4;
    localparam int SW_SELECT = 5;
    localparam int SW_MODE0  = 6;
    localparam int N_MODE    = 2;
endpackage

// File: rtl/switch_latch.sv
module switch_latch #(
    parameter int SEL_W = 3,
    localparam int N_SW = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             wr_val,
    output logic [N_SW-1:0]  sw
);
    for (genvar i = 0; i < N_SW; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                sw[i] <= 1'b0;
            else if (wr_en && (wr_sel == SEL_W'(i)))
                sw[i] <= wr_val;
        end

        // R2: unaddressed switch holds
        a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en || wr_sel != SEL_W'(i)) |=> $stable(sw[i]));
    end

    // R1: addressed switch takes the offset LSB
    a_r1_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sw[$past(wr_sel)] == $past(wr_val));
endmodule

// File: rtl/motor_timer.sv
module motor_timer
    import disk_latch_pkg::*;
#(
    parameter int DELAY_TICKS = 2_000_000,
    localparam int CNT_W = $clog2(DELAY_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic motor_on
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DELAY_TICKS);

    motor_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= M_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            M_OFF: begin
                if (req) begin
                    state_d = M_HELD;
                    cnt_d   = RELOAD;
                end
            end
            M_HELD: begin
                if (req) begin
                    cnt_d = RELOAD;
                end else begin
                    state_d = M_COAST;
                    cnt_d   = cnt_q - 1'b1;
                end
            end
            M_COAST: begin
                if (req) begin
                    state_d = M_HELD;
                    cnt_d   = RELOAD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1))
                        state_d = M_OFF;
                end
            end
            default: begin
                state_d = M_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    assign motor_on = (state_q != M_OFF);

    // R5: request reloads the full delay
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> cnt_q == RELOAD);
    // R6: coasting counts down by one per tick
    a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
    // R6: state and counter agree on motor-on
    a_r6_on_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        motor_on == (cnt_q != '0));
    // R7: a request while running never lets motor-on dip
    a_r7_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_on && req) |=> motor_on);
endmodule

// File: rtl/drive_gate.sv
module drive_gate #(
    parameter int N_DRV = 2
) (
    input  logic             motor_on,
    input  logic             sel,
    output logic [N_DRV-1:0] drv_en
);
    for (genvar d = 0; d < N_DRV; d++) begin : g_drv
        assign drv_en[d] = motor_on && (sel == d[0]);
    end
endmodule

// File: rtl/floppy_ctl_latch.sv
module floppy_ctl_latch
    import disk_latch_pkg::*;
#(
    parameter int OFS_W       = 4,
    parameter int DATA_W      = 8,
    parameter int DELAY_TICKS = 2_000_000,
    localparam int SEL_W = OFS_W - 1,
    localparam int N_SW  = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_stb,
    input  logic [OFS_W-1:0]  acc_ofs,
    input  logic [DATA_W-1:0] dreg_in,
    output logic              bus_oe,
    output logic [DATA_W-1:0] bus_dout,
    output logic [3:0]        phase,
    output logic [1:0]        mode,
    output logic              motor_on,
    output logic [1:0]        drv_en
);
    logic [N_SW-1:0] sw;

    switch_latch #(.SEL_W(SEL_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (acc_stb),
        .wr_sel (acc_ofs[OFS_W-1:1]),
        .wr_val (acc_ofs[0]),
        .sw     (sw)
    );

    motor_timer #(.DELAY_TICKS(DELAY_TICKS)) u_motor (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (sw[SW_MOTOR]),
        .motor_on (motor_on)
    );

    drive_gate #(.N_DRV(2)) u_gate (
        .motor_on (motor_on),
        .sel      (sw[SW_SELECT]),
        .drv_en   (drv_en)
    );

    assign bus_oe   = acc_stb && !acc_ofs[0];
    assign bus_dout = bus_oe ? dreg_in : '0;
    assign phase    = sw[SW_PHASE0 +: N_PHASE];
    assign mode     = sw[SW_MODE0 +: N_MODE];

    // R8: never both drives, none without motor
    a_r8_one_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_en));
    a_r8_idle_drives: assert property (@(posedge clk) disable iff (!rst_n)
        !motor_on |-> drv_en == 2'b00);
    // R3: bus stays released outside an even-offset access
    a_r3_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_stb || acc_ofs[0]) |-> (!bus_oe && bus_dout == '0));
endmodule

// File: tb/floppy_ctl_latch_tb.sv
module floppy_ctl_latch_tb;
    localparam int DELAY = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_stb = 1'b0;
    logic [3:0] acc_ofs = '0;
    logic [7:0] dreg_in = '0;
    logic       bus_oe;
    logic [7:0] bus_dout;
    logic [3:0] phase;
    logic [1:0] mode;
    logic       motor_on;
    logic [1:0] drv_en;

    floppy_ctl_latch #(.DELAY_TICKS(DELAY)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_ofs(acc_ofs),
        .dreg_in(dreg_in), .bus_oe(bus_oe), .bus_dout(bus_dout),
        .phase(phase), .mode(mode), .motor_on(motor_on), .drv_en(drv_en)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int         due;
        logic [3:0] ph;
        logic [1:0] md;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    int         cyc = 0;
    int         checks = 0;
    int         failures = 0;
    logic [7:0] sw_m = '0;
    logic [7:0] pat = 8'h5A;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor: compares switch outputs once they are due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(phase == e.ph, {e.tag, " phase"}, phase, e.ph);
            chk(mode == e.md, {e.tag, " mode"}, mode, e.md);
        end
    end

    // driver: one access, bus checked same cycle, switch state queued
    task automatic access(input logic [3:0] ofs, input string tag);
        exp_t e;
        @(negedge clk);
        pat = {pat[6:0], pat[7] ^ pat[5]} + 8'd3;
        acc_stb = 1'b1;
        acc_ofs = ofs;
        dreg_in = pat;
        #1;
        if (!ofs[0]) begin
            chk(bus_oe == 1'b1, "R3 oe even", bus_oe, 1);
            chk(bus_dout == pat, "R3 data even", bus_dout, pat);
        end else begin
            chk(bus_oe == 1'b0, "R3 oe odd", bus_oe, 0);
            chk(bus_dout == 8'h00, "R3 data odd", bus_dout, 0);
        end
        sw_m[ofs[3:1]] = ofs[0];
        e.due = cyc + 1;
        e.ph  = sw_m[3:0];
        e.md  = sw_m[7:6];
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_stb = 1'b0;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R4: reset state
        idle(3);
        chk({phase, mode} == 6'd0, "R4 switches in reset", {phase, mode}, 0);
        chk(motor_on == 1'b0, "R4 motor in reset", motor_on, 0);
        chk(drv_en == 2'b00, "R4 drives in reset", drv_en, 0);
        rst_n = 1'b1;
        idle(2);

        // R1 R9: walking set and clear over phases and modes
        for (int b = 0; b < 4; b++) access(4'(2 * b + 1), "R1 R9 set phase");
        access(4'd13, "R1 R9 set mode0");
        access(4'd2, "R1 clear phase1");
        access(4'd15, "R1 R9 set mode1");
        access(4'd6, "R1 clear phase3");
        access(4'd12, "R1 clear mode0");
        access(4'd4, "R1 clear phase2");
        // R2: idle cycles keep everything
        idle(5);
        chk(phase == 4'b0001, "R2 phase hold", phase, 4'b0001);
        chk(mode == 2'b10, "R2 mode hold", mode, 2'b10);
        chk(motor_on == 1'b0, "R2 motor untouched", motor_on, 0);

        // R5 R8: motor on, drive 0
        access(4'd9, "R5 motor request");
        idle(3);
        chk(motor_on == 1'b1, "R5 motor on", motor_on, 1);
        chk(drv_en == 2'b01, "R8 drive0", drv_en, 2'b01);
        access(4'd11, "R8 select drive1");
        idle(1);
        chk(drv_en == 2'b10, "R8 drive1", drv_en, 2'b10);
        idle(DELAY + 3);
        chk(motor_on == 1'b1, "R5 held past delay", motor_on, 1);

        // R6: exact off-delay
        access(4'd8, "R6 drop request");
        idle(DELAY);
        chk(motor_on == 1'b1, "R6 last on cycle", motor_on, 1);
        chk(drv_en == 2'b10, "R8 drive1 during coast", drv_en, 2'b10);
        idle(1);
        chk(motor_on == 1'b0, "R6 off after delay", motor_on, 0);
        chk(drv_en == 2'b00, "R8 drives off", drv_en, 0);

        // R7: re-request mid-delay, no glitch
        access(4'd9, "R7 request");
        idle(2);
        access(4'd8, "R7 drop");
        for (int i = 0; i < DELAY / 2; i++) begin
            idle(1);
            chk(motor_on == 1'b1, "R7 coasting", motor_on, 1);
        end
        access(4'd9, "R7 re-request");
        chk(motor_on == 1'b1, "R7 re-request cycle", motor_on, 1);
        for (int i = 0; i < 3; i++) begin
            idle(1);
            chk(motor_on == 1'b1, "R7 no glitch", motor_on, 1);
        end
        access(4'd8, "R7 second drop");
        idle(DELAY);
        chk(motor_on == 1'b1, "R7 full delay after reload", motor_on, 1);
        idle(1);
        chk(motor_on == 1'b0, "R7 off after reload", motor_on, 0);

        // R10: select change during coast
        access(4'd9, "R10 request");
        idle(2);
        access(4'd8, "R10 drop");
        access(4'd10, "R10 select drive0");
        idle(1);
        chk(drv_en == 2'b01, "R10 enable moved", drv_en, 2'b01);
        idle(DELAY - 2);
        chk(motor_on == 1'b1, "R10 delay kept", motor_on, 1);
        idle(1);
        chk(motor_on == 1'b0, "R10 delay not extended", motor_on, 0);

        // R4: reset mid-run
        access(4'd9, "R4 pre motor");
        access(4'd7, "R4 pre phase");
        idle(3);
        @(negedge clk);
        rst_n = 1'b0;
        idle(1);
        chk({phase, mode} == 6'd0, "R4 switches cleared", {phase, mode}, 0);
        chk(motor_on == 1'b0, "R4 motor cleared", motor_on, 0);
        chk(drv_en == 2'b00, "R4 drives cleared", drv_en, 0);
        sw_m = '0;
        rst_n = 1'b1;
        idle(2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule